// File: doc/BRIEF.md
# Overcurrent Hiccup Soft-Start Sequencer

This block is the control state machine of a synchronous buck converter. It orders start-up and fault recovery. Once power-on reset is released, it waits a fixed settling delay. It then runs a single phase in which the overcurrent threshold is captured while the low-side gate is held off. After that it runs a soft-start ramp with switching enabled and settles into regulation. The analog ramp, the threshold DAC, the current comparator and the gate drivers sit outside the block. They are reached through plain digital levels and strobes.

When the overcurrent detector fires, the gate drive is withdrawn at once and the block enters hiccup mode. Each hiccup cycle has two idle soft-start periods with every output off, followed by one real soft-start attempt. The cycle repeats for as long as the fault lasts. Retries never recapture the threshold. Only a shutdown followed by re-enable runs the full initialization again, including a new capture. The enable and overcurrent inputs are asynchronous and pass through two flip-flops each before use. All period lengths are parameters counted in clock cycles.

Top module: `hiccup_seq`

## Requirements
- R1: While `rst` is high or `por_ok` is low, `state_o` is 0 (reset wait), and `gate_en`, `ramp_en` and `cap_strobe` are all 0.
- R2: After `por_ok` rises, the reset-wait state (code 0) lasts exactly `POR_CYC` clock cycles.
- R3: The capture state (code 1) follows reset wait and lasts exactly `CAP_CYC` cycles with `gate_en` low. `cap_strobe` pulses high for exactly one cycle, in the last capture cycle.
- R4: Soft-start (code 2) drives `gate_en` and `ramp_en` high and lasts exactly `SS_CYC` cycles. It then moves to run (code 3), where `gate_en` is 1 and `ramp_en` is 0.
- R5: An overcurrent pulse of at least one cycle on `oc_in` during run forces state 4 and `gate_en` low. This happens on the third rising clock edge after the pulse is applied (two synchronizer stages plus the state register).
- R6: A hiccup cycle runs state 4 for `SS_CYC` cycles, then state 5 for `SS_CYC` cycles, both with `gate_en` and `ramp_en` low, and then re-enters soft-start (code 2) without a capture strobe.
- R7: An overcurrent seen during soft-start aborts it into state 4 with the same three-edge latency.
- R8: While overcurrent persists, hiccup cycles repeat without end, and no `cap_strobe` is issued during them.
- R9: `en_in` low forces state 6 (shutdown) with all outputs low, three edges after it falls. Once `en_in` is high again, the block restarts from state 0 with a full `POR_CYC` wait and a new capture.
- R10: Overcurrent is ignored in reset wait, capture, the hiccup states and shutdown. A pulse during capture leaves the sequence going on to soft-start and then run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok | input | 1 | High once power-on reset has released |
| en_in | input | 1 | Asynchronous enable; low requests shutdown |
| oc_in | input | 1 | Asynchronous overcurrent detect |
| gate_en | output | 1 | Switching permitted for both gate drivers |
| ramp_en | output | 1 | Soft-start ramp generator active |
| cap_strobe | output | 1 | One-cycle strobe that latches the overcurrent threshold |
| state_o | output | 3 | Current sequencer state code |

## Verification
The embedded properties check the following on every cycle:
- the legal predecessors of capture, soft-start and the second hiccup state;
- the forced moves on loss of power-good, on disable and on overcurrent in a switching state;
- the single-cycle width of the capture strobe;
- that the period counter stays below its limit.

The directed scenarios are needed for the rest:
- the exact period lengths;
- the three-edge reaction latency through the synchronizers;
- the absence of a recapture across many hiccup rounds;
- the full re-initialization after shutdown;
- the fact that an overcurrent pulse during capture leaves the normal start-up path unchanged.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

    typedef enum logic [2:0] {
        ST_RESET_WAIT    = 3'd0,
        ST_CAPTURE       = 3'd1,
        ST_SOFTSTART     = 3'd2,
        ST_RUN           = 3'd3,
        ST_HICCUP_DUMMY1 = 3'd4,
        ST_HICCUP_DUMMY2 = 3'd5,
        ST_SHUTDOWN      = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic gate_en;
        logic ramp_en;
    } drive_t;

    function automatic drive_t drive_of(seq_state_e s);
        drive_t d;
        d.gate_en = (s == ST_SOFTSTART) || (s == ST_RUN);
        d.ramp_en = (s == ST_SOFTSTART);
        return d;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hs_timer.sv
module hs_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [CW-1:0] lim,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (!done) cnt_q <= cnt_q + CW'(1);
    end

    assign done = (cnt_q == lim - CW'(1));

    AST_TMR_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt_q < lim); // R2
endmodule

// File: rtl/hs_fsm.sv
module hs_fsm
    import hiccup_pkg::*;
#(
    parameter int unsigned POR_CYC = 20,
    parameter int unsigned CAP_CYC = 4,
    parameter int unsigned SS_CYC  = 10,
    parameter int unsigned CW      = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          por_ok,
    input  logic          en_s,
    input  logic          oc_s,
    input  logic          tmr_done,
    output logic          tmr_clr,
    output logic [CW-1:0] tmr_lim,
    output logic          cap_strobe,
    output seq_state_e    state_q
);
    seq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET_WAIT:    if (tmr_done) state_d = ST_CAPTURE;
            ST_CAPTURE:       if (tmr_done) state_d = ST_SOFTSTART;
            ST_SOFTSTART: begin
                if (oc_s)          state_d = ST_HICCUP_DUMMY1;
                else if (tmr_done) state_d = ST_RUN;
            end
            ST_RUN:           if (oc_s) state_d = ST_HICCUP_DUMMY1;
            ST_HICCUP_DUMMY1: if (tmr_done) state_d = ST_HICCUP_DUMMY2;
            ST_HICCUP_DUMMY2: if (tmr_done) state_d = ST_SOFTSTART;
            ST_SHUTDOWN:      if (en_s) state_d = ST_RESET_WAIT;
            default:          state_d = ST_RESET_WAIT;
        endcase
        if (!en_s)   state_d = ST_SHUTDOWN;
        if (!por_ok) state_d = ST_RESET_WAIT;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RESET_WAIT;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RESET_WAIT: tmr_lim = CW'(POR_CYC);
            ST_CAPTURE:    tmr_lim = CW'(CAP_CYC);
            default:       tmr_lim = CW'(SS_CYC);
        endcase
    end

    assign tmr_clr    = (state_d != state_q) || !por_ok;
    assign cap_strobe = (state_q == ST_CAPTURE) && tmr_done && por_ok && en_s;

    AST_POR_HOLDS_WAIT: assert property (@(posedge clk) disable iff (rst)
        !por_ok |=> state_q == ST_RESET_WAIT); // R1
    AST_CAPTURE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CAPTURE && $past(state_q) != ST_CAPTURE) |-> $past(state_q) == ST_RESET_WAIT); // R3
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cap_strobe |=> !cap_strobe); // R3
    AST_OC_TRIPS: assert property (@(posedge clk) disable iff (rst)
        (por_ok && en_s && oc_s && (state_q == ST_RUN || state_q == ST_SOFTSTART))
            |=> state_q == ST_HICCUP_DUMMY1); // R5
    AST_DUMMY_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HICCUP_DUMMY2 && $past(state_q) != ST_HICCUP_DUMMY2)
            |-> $past(state_q) == ST_HICCUP_DUMMY1); // R6
    AST_SS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SOFTSTART && $past(state_q) != ST_SOFTSTART)
            |-> ($past(state_q) == ST_CAPTURE || $past(state_q) == ST_HICCUP_DUMMY2)); // R8
    AST_DISABLE_SHUTS: assert property (@(posedge clk) disable iff (rst)
        (por_ok && !en_s) |=> state_q == ST_SHUTDOWN); // R9
endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq
    import hiccup_pkg::*;
#(
    parameter int unsigned POR_CYC     = 1360000,
    parameter int unsigned CAP_CYC     = 64,
    parameter int unsigned SS_CYC      = 200000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por_ok,
    input  logic       en_in,
    input  logic       oc_in,
    output logic       gate_en,
    output logic       ramp_en,
    output logic       cap_strobe,
    output logic [2:0] state_o
);
    localparam int unsigned MAX_CYC = max3(POR_CYC, CAP_CYC, SS_CYC);
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);

    logic [1:0]    sync_q;
    logic          tmr_done, tmr_clr;
    logic [CW-1:0] tmr_lim;
    seq_state_e    state;
    drive_t        drv;

    hs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({en_in, oc_in}),
        .q   (sync_q)
    );

    hs_timer #(.CW(CW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (tmr_clr),
        .lim  (tmr_lim),
        .done (tmr_done)
    );

    hs_fsm #(
        .POR_CYC (POR_CYC),
        .CAP_CYC (CAP_CYC),
        .SS_CYC  (SS_CYC),
        .CW      (CW)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .por_ok     (por_ok),
        .en_s       (sync_q[1]),
        .oc_s       (sync_q[0]),
        .tmr_done   (tmr_done),
        .tmr_clr    (tmr_clr),
        .tmr_lim    (tmr_lim),
        .cap_strobe (cap_strobe),
        .state_q    (state)
    );

    assign drv     = drive_of(state);
    assign gate_en = drv.gate_en;
    assign ramp_en = drv.ramp_en;
    assign state_o = state;
endmodule

// File: tb/hiccup_seq_tb.sv
`timescale 1ns/1ps
module hiccup_seq_tb;
    localparam int POR = 20;
    localparam int CAP = 4;
    localparam int SS  = 10;

    logic clk = 1'b0;
    logic rst, por_ok, en_in, oc_in;
    logic gate_en, ramp_en, cap_strobe;
    logic [2:0] state_o;
    int checks = 0;
    int fails  = 0;
    int strobes = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hiccup_seq #(.POR_CYC(POR), .CAP_CYC(CAP), .SS_CYC(SS)) u_dut (
        .clk(clk), .rst(rst), .por_ok(por_ok), .en_in(en_in), .oc_in(oc_in),
        .gate_en(gate_en), .ramp_en(ramp_en), .cap_strobe(cap_strobe), .state_o(state_o)
    );

    always @(negedge clk) if (cap_strobe) strobes++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic measure(input logic [2:0] st, output int n);
        n = 0;
        while (state_o == st && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_st(input logic [2:0] st, input string req);
        int k = 0;
        while (state_o != st && k < 5000) begin
            k++;
            @(negedge clk);
        end
        chk(state_o == st, req, state_o, st);
    endtask

    task automatic t_reset();
        rst = 1'b1; por_ok = 1'b0; en_in = 1'b1; oc_in = 1'b0;
        repeat (4) @(negedge clk);
        chk(state_o == 3'd0 && !gate_en && !ramp_en && !cap_strobe, "R1 in reset", state_o, 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk(state_o == 3'd0 && !gate_en && !ramp_en, "R1 por low", state_o, 0);
    endtask

    task automatic t_boot();
        int n, s0;
        por_ok = 1'b1;
        measure(3'd0, n);
        chk(n == POR, "R2 wait length", n, POR);
        s0 = strobes;
        chk(state_o == 3'd1 && !gate_en, "R3 capture gate off", state_o, 1);
        measure(3'd1, n);
        chk(n == CAP, "R3 capture length", n, CAP);
        chk(strobes - s0 == 1, "R3 one strobe", strobes - s0, 1);
        chk(gate_en && ramp_en, "R4 softstart drives", {gate_en, ramp_en}, 3);
        measure(3'd2, n);
        chk(n == SS, "R4 softstart length", n, SS);
        chk(state_o == 3'd3 && gate_en && !ramp_en, "R4 run", state_o, 3);
    endtask

    task automatic t_oc_run();
        int n, s0;
        s0 = strobes;
        oc_in = 1'b1;
        @(negedge clk); oc_in = 1'b0;
        @(negedge clk);
        chk(gate_en == 1'b1, "R5 gate before latency", gate_en, 1);
        @(negedge clk);
        chk(state_o == 3'd4 && !gate_en, "R5 trip to dummy1", state_o, 4);
        chk(!ramp_en, "R6 dummy ramp off", ramp_en, 0);
        measure(3'd4, n);
        chk(n == SS, "R6 dummy1 length", n, SS);
        chk(state_o == 3'd5 && !gate_en, "R6 dummy2 entered", state_o, 5);
        measure(3'd5, n);
        chk(n == SS, "R6 dummy2 length", n, SS);
        chk(state_o == 3'd2, "R6 real softstart", state_o, 2);
        chk(strobes == s0, "R6 no recapture", strobes - s0, 0);
        wait_st(3'd3, "R6 back to run");
    endtask

    task automatic t_oc_ss();
        oc_in = 1'b1;
        @(negedge clk); oc_in = 1'b0;
        wait_st(3'd2, "R7 reach softstart");
        oc_in = 1'b1;
        @(negedge clk); oc_in = 1'b0;
        @(negedge clk);
        chk(state_o == 3'd2, "R7 still softstart", state_o, 2);
        @(negedge clk);
        chk(state_o == 3'd4 && !gate_en, "R7 softstart aborted", state_o, 4);
        wait_st(3'd3, "R7 recover run");
    endtask

    task automatic t_persist();
        int s0 = strobes;
        oc_in = 1'b1;
        for (int i = 0; i < 3; i++) begin
            wait_st(3'd4, "R8 dummy1 repeat");
            wait_st(3'd5, "R8 dummy2 repeat");
            wait_st(3'd2, "R8 softstart repeat");
        end
        chk(strobes == s0, "R8 no capture in retries", strobes - s0, 0);
        oc_in = 1'b0;
        wait_st(3'd3, "R8 run after fault clears");
    endtask

    task automatic t_shutdown();
        int n, s0;
        en_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(state_o == 3'd3, "R9 before latency", state_o, 3);
        @(negedge clk);
        chk(state_o == 3'd6 && !gate_en && !ramp_en, "R9 shutdown", state_o, 6);
        repeat (10) @(negedge clk);
        chk(state_o == 3'd6, "R9 holds shutdown", state_o, 6);
        en_in = 1'b1;
        wait_st(3'd0, "R9 restart wait");
        measure(3'd0, n);
        chk(n == POR, "R9 full wait", n, POR);
        s0 = strobes;
        chk(state_o == 3'd1, "R9 recapture state", state_o, 1);
        oc_in = 1'b1;
        @(negedge clk); oc_in = 1'b0;
        wait_st(3'd2, "R10 capture ignores oc");
        chk(strobes - s0 == 1, "R9 new strobe", strobes - s0, 1);
        measure(3'd2, n);
        chk(state_o == 3'd3, "R10 run not hiccup", state_o, 3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_boot();
        t_oc_run();
        t_oc_ss();
        t_persist();
        t_shutdown();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule